// File: doc/BRIEF.md
# Circular Trace Capture Buffer with Trigger Marker

This block is an on-chip memory that records a stream of trace words. Once armed, it stores every valid word at the next position of a circular write pointer. When the pointer runs past the last entry it starts again at zero, and the oldest entries are overwritten. Capture continues in this way until something stops it. Stopping capture only stops writes into the memory. The traced processor keeps running whatever the buffer does.

A trigger input marks a point of interest in the trace. The first trigger hit after arming writes a reserved marker word into the stream. If stop-on-trigger is selected, the block then accepts a programmed number of further words and freezes. The post-trigger count therefore decides where the marker sits in the frozen buffer:

- A count of zero leaves the marker as the newest entry.
- Half the depth leaves it near the middle.
- The maximum count leaves it as the oldest entry.

Software reads the contents through an address/data port. It uses the write pointer and the wrapped flag to find the oldest valid entry.

Top module: `circ_trace_buf`

## Requirements
- R1: After reset the block is idle. The write pointer is 0, and `wrapped`, `triggered` and `frozen` are all 0. Trace words and trigger hits have no effect until the first `arm` pulse.
- R2: An `arm` pulse clears `wrapped`, `triggered` and `frozen`, sets the write pointer to 0 and starts capture. `arm` takes priority over every other input in its cycle.
- R3: While capturing, each valid trace word is written at the write pointer, and the pointer then advances by one modulo DEPTH. Words are stored in arrival order.
- R4: `wrapped` rises the first time the write pointer rolls over from DEPTH-1 to 0. It stays set until the next arm.
- R5: Only the first trigger hit after arming is acted on. It sets `triggered`, and in the next cycle the marker word MARKER_WORD (default 16'hFFFF) is written. The marker follows any word that was valid in the trigger cycle. Later trigger hits do not write another marker.
- R6: A trace word that is valid in the cycle the marker is written is delayed, not lost. It is stored directly after the marker, and arrival order is kept for all later words.
- R7: With `stopOnTrig` low, the trigger only inserts the marker, and capture continues with `frozen` staying 0.
- R8: With `stopOnTrig` high, exactly P further words are written after the marker, and then `frozen` rises. P = 0 freezes capture right after the marker write.
- R9: A `postCount` request above DEPTH-1 is clamped to DEPTH-1. With the clamped value, the marker becomes the oldest entry of the full buffer.
- R10: While frozen, no word is written and the write pointer holds. `rdData` shows the entry at `rdAddr` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Pulse: clear flags and pointer, start capture |
| stopOnTrig | input | 1 | Freeze capture after the post-trigger words |
| postCount | input | $clog2(DEPTH)+1 | Words to capture after the marker (clamped) |
| traceValid | input | 1 | Trace word valid |
| traceData | input | DATA_W | Trace word |
| trigHit | input | 1 | Trigger condition this cycle |
| rdAddr | input | $clog2(DEPTH) | Read address |
| rdData | output | DATA_W | Entry at rdAddr (combinational) |
| wrPtr | output | $clog2(DEPTH) | Next write position |
| wrapped | output | 1 | Pointer has rolled over since arming |
| triggered | output | 1 | First trigger taken since arming |
| frozen | output | 1 | Capture stopped after trigger |

## Verification
The hardest case to reach from the ports is a marker write that collides with a valid trace word, followed by an unbroken stream. In that case every later word passes through the one-entry holding register, and the post-trigger count must still land exactly. The stimulus drives a continuous stream across the trigger, a second trigger during the countdown and a stream long enough to wrap. A scoreboard queue holds the expected word order with the marker placed after the trigger-cycle word. The frozen memory is compared against the tail of that queue, read from oldest to newest.

// File: rtl/trace_buf_pkg.sv
package trace_buf_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_POST,
    ST_FROZEN
  } capState_t;

  typedef struct packed {
    logic clear;      // rearm: reset pointer, flags and holding register
    logic wrEn;       // write one entry this cycle
    logic selMarker;  // the entry is the marker word
    logic selHold;    // the entry comes from the holding register
    logic loadHold;   // capture the incoming word into the holding register
  } dpStrobes_t;

endpackage

// File: rtl/tbuf_datapath.sv
module tbuf_datapath
  import trace_buf_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH = 16,
  parameter logic [DATA_W-1:0] MARKER_WORD = '1,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dpStrobes_t        stb,
  input  logic              traceValid,
  input  logic [DATA_W-1:0] traceData,
  input  logic [PTR_W-1:0]  rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic [PTR_W-1:0]  wrPtr,
  output logic              wrapped,
  output logic              holdValid
);

  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] holdReg;
  logic [DATA_W-1:0] wrWord;

  always_comb begin
    if (stb.selMarker) wrWord = MARKER_WORD;
    else if (stb.selHold) wrWord = holdReg;
    else wrWord = traceData;
  end

  // Storage array: no reset, written one entry per cycle
  always_ff @(posedge clk) begin
    if (stb.wrEn && !stb.clear) mem[wrPtr] <= wrWord;
  end

  assign rdData = mem[rdAddr];

  always_ff @(posedge clk) begin
    if (!rst_n || stb.clear) begin
      wrPtr   <= '0;
      wrapped <= 1'b0;
    end else if (stb.wrEn) begin
      wrPtr <= wrPtr + 1'b1;
      if (wrPtr == LAST_IDX) wrapped <= 1'b1;
    end
  end

  // One-entry skid register for words that collide with the marker
  always_ff @(posedge clk) begin
    if (!rst_n || stb.clear) begin
      holdValid <= 1'b0;
      holdReg   <= '0;
    end else if (stb.loadHold) begin
      holdValid <= traceValid;
      holdReg   <= traceData;
    end
  end

  a_r3_ptr_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.wrEn && !stb.clear) |=> wrPtr == PTR_W'($past(wrPtr) + 1'b1));

  a_r4_wrapped_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (wrapped && !stb.clear) |=> wrapped);

  a_r2_clear_state: assert property (@(posedge clk) disable iff (!rst_n)
    stb.clear |=> (wrPtr == '0 && !wrapped && !holdValid));

endmodule

// File: rtl/tbuf_control.sv
module tbuf_control
  import trace_buf_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             stopOnTrig,
  input  logic [CNT_W:0]   postCount,
  input  logic             traceValid,
  input  logic             trigHit,
  input  logic             holdValid,
  output dpStrobes_t       stb,
  output logic             frozen,
  output logic             triggered
);

  localparam logic [CNT_W:0] MAX_POST = (CNT_W + 1)'(DEPTH - 1);

  capState_t        state;
  logic             markerPending;
  logic [CNT_W-1:0] postLeft;
  logic [CNT_W-1:0] postClamped;
  logic             capturing;

  assign capturing = (state == ST_RUN) || (state == ST_POST);
  assign frozen    = (state == ST_FROZEN);

  always_comb begin
    if (postCount > MAX_POST) postClamped = MAX_POST[CNT_W-1:0];
    else postClamped = postCount[CNT_W-1:0];
  end

  // Write arbitration: marker first, then the held word, then live data
  always_comb begin
    stb = '0;
    if (arm) begin
      stb.clear = 1'b1;
    end else if (capturing) begin
      if (markerPending) begin
        stb.wrEn      = 1'b1;
        stb.selMarker = 1'b1;
        stb.loadHold  = 1'b1;
      end else if (holdValid) begin
        stb.wrEn     = 1'b1;
        stb.selHold  = 1'b1;
        stb.loadHold = 1'b1;
      end else begin
        stb.wrEn = traceValid;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state         <= ST_IDLE;
      triggered     <= 1'b0;
      markerPending <= 1'b0;
      postLeft      <= '0;
    end else if (arm) begin
      state         <= ST_RUN;
      triggered     <= 1'b0;
      markerPending <= 1'b0;
      postLeft      <= '0;
    end else begin
      if (capturing && !triggered && trigHit) begin
        triggered     <= 1'b1;
        markerPending <= 1'b1;
      end
      if (stb.selMarker) begin
        markerPending <= 1'b0;
        if (stopOnTrig) begin
          if (postClamped == '0) begin
            state <= ST_FROZEN;
          end else begin
            state    <= ST_POST;
            postLeft <= postClamped;
          end
        end
      end else if (state == ST_POST && stb.wrEn) begin
        if (postLeft == CNT_W'(1)) state <= ST_FROZEN;
        else postLeft <= postLeft - 1'b1;
      end
    end
  end

  a_r5_single_marker: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(markerPending) |-> $rose(triggered));

  a_r6_hold_on_collision: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.selMarker && traceValid && !arm) |=> holdValid);

  a_r8_frozen_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !arm) |=> frozen);

endmodule

// File: rtl/circ_trace_buf.sv
module circ_trace_buf
  import trace_buf_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH = 16,
  parameter logic [DATA_W-1:0] MARKER_WORD = '1,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              stopOnTrig,
  input  logic [PTR_W:0]    postCount,
  input  logic              traceValid,
  input  logic [DATA_W-1:0] traceData,
  input  logic              trigHit,
  input  logic [PTR_W-1:0]  rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic [PTR_W-1:0]  wrPtr,
  output logic              wrapped,
  output logic              triggered,
  output logic              frozen
);

  dpStrobes_t stb;
  logic       holdValid;

  tbuf_control #(.DEPTH(DEPTH)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm        (arm),
    .stopOnTrig (stopOnTrig),
    .postCount  (postCount),
    .traceValid (traceValid),
    .trigHit    (trigHit),
    .holdValid  (holdValid),
    .stb        (stb),
    .frozen     (frozen),
    .triggered  (triggered)
  );

  tbuf_datapath #(
    .DATA_W      (DATA_W),
    .DEPTH       (DEPTH),
    .MARKER_WORD (MARKER_WORD)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .stb        (stb),
    .traceValid (traceValid),
    .traceData  (traceData),
    .rdAddr     (rdAddr),
    .rdData     (rdData),
    .wrPtr      (wrPtr),
    .wrapped    (wrapped),
    .holdValid  (holdValid)
  );

  a_r10_frozen_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !arm) |=> $stable(wrPtr));

  a_r1_idle_no_trigger: assert property (@(posedge clk) disable iff (!rst_n)
    (!triggered && !frozen && wrPtr == '0 && !wrapped && !arm && !traceValid && !trigHit
     && !$rose(triggered)) |=> !frozen);

endmodule

// File: tb/tb_circ_trace_buf.sv
module tb_circ_trace_buf;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int PW = 4;
  localparam logic [15:0] MARK = 16'hFFFF;

  logic clk = 0, rst_n = 0, arm = 0, stopOnTrig = 0, traceValid = 0, trigHit = 0;
  logic [PW:0] postCount = '0;
  logic [15:0] traceData = '0;
  logic [PW-1:0] rdAddr = '0;
  logic [15:0] rdData;
  logic [PW-1:0] wrPtr;
  logic wrapped, triggered, frozen;

  circ_trace_buf dut (
    .clk(clk), .rst_n(rst_n), .arm(arm), .stopOnTrig(stopOnTrig), .postCount(postCount),
    .traceValid(traceValid), .traceData(traceData), .trigHit(trigHit), .rdAddr(rdAddr),
    .rdData(rdData), .wrPtr(wrPtr), .wrapped(wrapped), .triggered(triggered), .frozen(frozen)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int nChecks = 0, nFail = 0;
  logic [15:0] expQ[$];
  int markerIdx = -1;
  bit trigTaken = 0, tbCap = 0, stopMode = 0;
  int postReq = 0;

  task automatic check(bit ok, string req, string what, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    nFail++; nChecks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  // Driver: one cycle of stimulus, pushes expected stored items
  task automatic cyc(bit v, logic [15:0] d, bit t);
    @(negedge clk);
    traceValid = v; traceData = d; trigHit = t; arm = 0;
    if (tbCap && v) expQ.push_back(d);
    if (tbCap && t && !trigTaken) begin
      trigTaken = 1;
      expQ.push_back(MARK);
      markerIdx = expQ.size() - 1;
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 16'h0, 0);
  endtask

  task automatic doArm(bit stop, int post);
    @(negedge clk);
    arm = 1; stopOnTrig = stop; postCount = post[PW:0];
    traceValid = 0; trigHit = 0;
    expQ.delete(); trigTaken = 0; markerIdx = -1;
    stopMode = stop; postReq = (post > DEPTH - 1) ? DEPTH - 1 : post; tbCap = 1;
    @(negedge clk);
    arm = 0;
  endtask

  // Monitor: reads the buffer oldest to newest and pops the expected tail
  task automatic scoreboard(string req);
    int stored, n, start;
    logic [15:0] tail[$];
    idle(3);
    stored = (stopMode && trigTaken) ? markerIdx + 1 + postReq : expQ.size();
    if (stored > expQ.size()) stored = expQ.size();
    check(wrPtr == PW'(stored % DEPTH), req, "wrPtr", wrPtr, stored % DEPTH);
    check(wrapped == (stored >= DEPTH), req, "wrapped", wrapped, stored >= DEPTH);
    n = (stored < DEPTH) ? stored : DEPTH;
    start = (stored >= DEPTH) ? stored % DEPTH : 0;
    for (int k = stored - n; k < stored; k++) tail.push_back(expQ[k]);
    for (int k = 0; k < n; k++) begin
      logic [15:0] e;
      rdAddr = PW'((start + k) % DEPTH);
      #1;
      e = tail.pop_front();
      check(rdData == e, req, "entry", rdData, e);
    end
  endtask

  task automatic countMarkers(string req, int exp);
    int c = 0;
    for (int a = 0; a < DEPTH; a++) begin
      rdAddr = PW'(a); #1;
      if (rdData == MARK) c++;
    end
    check(c == exp, req, "marker count", c, exp);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    // R1: reset state and idle ignores inputs
    check(wrPtr == 0 && !wrapped && !triggered && !frozen, "R1", "reset flags",
          {wrPtr, wrapped, triggered, frozen}, 0);
    cyc(1, 16'h0011, 1); cyc(1, 16'h0012, 0); idle(2);
    check(wrPtr == 0 && !triggered, "R1", "idle ignores stream", {wrPtr, triggered}, 0);

    // R3: plain capture in order
    doArm(0, 0);
    for (int i = 0; i < 10; i++) cyc(1, 16'h0100 + 16'(i), 0);
    scoreboard("R3");

    // R4: wrap-around
    doArm(0, 0);
    for (int i = 0; i < 20; i++) cyc(1, 16'h0200 + 16'(i), 0);
    scoreboard("R4");

    // R8: post count zero, marker newest
    doArm(1, 0);
    for (int i = 0; i < 10; i++) cyc(1, 16'h0300 + 16'(i), i == 4);
    scoreboard("R8");
    check(frozen && triggered, "R8", "frozen after marker", {frozen, triggered}, 3);
    // R10: frozen ignores further words
    for (int i = 0; i < 3; i++) cyc(1, 16'h0350 + 16'(i), 0);
    idle(2);
    check(wrPtr == 6, "R10", "pointer holds when frozen", wrPtr, 6);

    // R6/R8/R5: continuous stream across trigger, half-depth post count, second trigger
    doArm(1, 8);
    for (int i = 0; i < 32; i++) cyc(1, 16'h0400 + 16'(i), i == 12 || i == 15);
    scoreboard("R6");
    check(frozen, "R8", "frozen after 8 words", frozen, 1);
    countMarkers("R5", 1);

    // R9: clamp; marker becomes oldest entry
    doArm(1, 25);
    for (int i = 0; i < 24; i++) cyc(1, 16'h0500 + 16'(i), i == 4);
    scoreboard("R9");
    rdAddr = wrPtr; #1;
    check(rdData == MARK, "R9", "oldest is marker", rdData, MARK);

    // R7: no stop on trigger, two triggers
    doArm(0, 0);
    for (int i = 0; i < 11; i++) cyc(1, 16'h0600 + 16'(i), i == 3 || i == 8);
    scoreboard("R7");
    check(!frozen && triggered, "R7", "keeps capturing", {frozen, triggered}, 1);
    countMarkers("R5", 1);
    for (int i = 0; i < 3; i++) cyc(1, 16'h0680 + 16'(i), 0);
    idle(2);
    check(wrPtr == 15, "R7", "capture continues", wrPtr, 15);

    // R5: trigger in an idle cycle, gapped data afterwards
    doArm(1, 3);
    for (int i = 0; i < 3; i++) cyc(1, 16'h0700 + 16'(i), 0);
    cyc(0, 16'h0, 1);
    cyc(0, 16'h0, 0);
    for (int i = 0; i < 6; i++) begin cyc(1, 16'h0710 + 16'(i), 0); cyc(0, 16'h0, 0); end
    scoreboard("R5");

    // R2: rearm clears everything
    doArm(0, 0);
    check(wrPtr == 0 && !wrapped && !triggered && !frozen, "R2", "rearm clears",
          {wrPtr, wrapped, triggered, frozen}, 0);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule